// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

The block keeps a free-running time value for precision time protocol timestamping. It holds a 40-bit nanosecond count and a 32-bit fractional-nanosecond accumulator beneath it. On every reference tick the block adds a fixed nominal step of 8 ns. It also adds or subtracts a software-programmed fractional correction. The carry or borrow out of the accumulator moves the nanosecond count by one. Software trims the rate by writing a sign-magnitude correction word.

Software reaches the block through a 32-bit register port with four word slots. Multi-word access is atomic. A read of the low time word captures the upper bits, so a later read of the high word returns the same instant. A write of the low word is only staged. The following write of the high word loads the full nanosecond value in a single cycle and clears the fraction. A halt bit in the auxiliary word freezes counting. The live time is also driven on output ports so that other blocks can capture timestamps from it.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the nanosecond count and the fraction are zero, the increment word (slot 2) reads 0 and the auxiliary word (slot 3) reads 0x8000_0000, meaning the counter is halted.
- R2: While bit 31 of the auxiliary word is 1, ticks leave both the nanosecond count and the fraction unchanged.
- R3: With a zero correction, each cycle that has `tick_i` high and no halt adds exactly 8 to the nanosecond count and leaves the fraction unchanged. A cycle without a tick changes nothing.
- R4: When bit 31 of the increment word is 0, each tick adds the magnitude in bits 30:0 to the fraction. A carry out of the 32-bit fraction adds 1 ns on top of the 8 ns step.
- R5: When bit 31 of the increment word is 1, each tick subtracts the magnitude from the fraction. A borrow takes 1 ns from the 8 ns step.
- R6: A read of slot 0 returns the live bits 31:0 and captures bits 39:32. A later read of slot 1 returns the captured value even if the count has since crossed a 2^32 boundary.
- R7: A write to slot 0 leaves the time unchanged. A following write to slot 1 loads {wdata[7:0], staged low word} as the nanosecond count and zeroes the fraction, visible on the next cycle.
- R8: Bits 31:8 of a slot-1 read are zero, and bits 31:8 of a slot-1 write are ignored.
- R9: The nanosecond count wraps modulo 2^40.
- R10: The increment word and the halt bit read back as written.
- R11: A slot-1 write in the same cycle as a tick wins: the loaded value appears without the tick's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick, advances the time once per high cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Word slot: 0 time low, 1 time high, 2 increment, 3 auxiliary |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of `reg_re_i`, zero otherwise |
| time_ns_o | output | 40 | Live nanosecond count |
| time_frac_o | output | 32 | Live fractional-nanosecond accumulator |

## Verification
The assertions assume that `reg_we_i` and `reg_re_i` are never high together. They also assume that a slot-1 write is the only event that may land on a tick cycle. The stimulus honours both: every register access occupies one cycle with `tick_i` low, except for one deliberate write-on-tick case. The per-tick window check assumes a correction magnitude below 2^31, so a single tick produces at most one carry or borrow. The sweep uses magnitudes from 1 up to 0x7FFF_FFFF of both signs and compares every tick against a 72-bit arithmetic model.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  typedef enum logic [1:0] {
    SLOT_TIME_LO = 2'd0,
    SLOT_TIME_HI = 2'd1,
    SLOT_INCR    = 2'd2,
    SLOT_AUX     = 2'd3
  } slot_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SIGN_BIT  = 31;
  localparam int unsigned MAG_W     = 31;
  localparam int unsigned HALT_BIT  = 31;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NS_W-1:0]   live_ns_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              inc_neg_o,
  output logic [MAG_W-1:0]  inc_mag_o,
  output logic              halt_o,
  output logic              load_o,
  output logic [NS_W-1:0]   load_ns_o
);
  localparam int unsigned HI_W = NS_W - WORD_W;

  logic [WORD_W-1:0] wr_lo_q;
  logic [HI_W-1:0]   rd_hi_q;
  logic [WORD_W-1:0] inc_q;
  logic              halt_q;
  logic [WORD_W-1:0] hi_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_lo_q <= '0;
      rd_hi_q <= '0;
      inc_q   <= '0;
      halt_q  <= 1'b1;
    end else begin
      if (re_i && slot_e'(addr_i) == SLOT_TIME_LO)
        rd_hi_q <= live_ns_i[NS_W-1:WORD_W];
      if (we_i) begin
        unique case (slot_e'(addr_i))
          SLOT_TIME_LO: wr_lo_q <= wdata_i;
          SLOT_TIME_HI: ;
          SLOT_INCR:    inc_q   <= wdata_i;
          SLOT_AUX:     halt_q  <= wdata_i[HALT_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    hi_word = '0;
    hi_word[HI_W-1:0] = rd_hi_q;
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (slot_e'(addr_i))
        SLOT_TIME_LO: rdata_o = live_ns_i[WORD_W-1:0];
        SLOT_TIME_HI: rdata_o = hi_word;
        SLOT_INCR:    rdata_o = inc_q;
        SLOT_AUX:     rdata_o = {halt_q, {(WORD_W-1){1'b0}}};
        default:      rdata_o = '0;
      endcase
    end
  end

  assign inc_neg_o = inc_q[SIGN_BIT];
  assign inc_mag_o = inc_q[MAG_W-1:0];
  assign halt_o    = halt_q;
  assign load_o    = we_i && slot_e'(addr_i) == SLOT_TIME_HI;
  assign load_ns_o = {wdata_i[HI_W-1:0], wr_lo_q};
endmodule

// File: rtl/ptp_tc_frac.sv
module ptp_tc_frac
  import ptp_tc_pkg::*;
#(
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              clr_i,
  input  logic              neg_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              carry_up_o,
  output logic              carry_dn_o
);
  localparam int unsigned SUM_W = FRAC_W + 2;

  logic [FRAC_W-1:0] frac_q;
  logic [SUM_W-1:0]  mag_ext;
  logic [SUM_W-1:0]  addend;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    mag_ext = SUM_W'(mag_i);
    addend  = neg_i ? (~mag_ext + SUM_W'(1)) : mag_ext;
    sum     = {2'b00, frac_q} + addend;
  end

  // top two bits of the signed sum: 01 carry, 11 borrow
  assign carry_up_o = adv_i && !sum[SUM_W-1] && sum[SUM_W-2];
  assign carry_dn_o = adv_i && sum[SUM_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frac_q <= '0;
    else if (clr_i) frac_q <= '0;
    else if (adv_i) frac_q <= sum[FRAC_W-1:0];
  end

  assign frac_o = frac_q;
endmodule

// File: rtl/ptp_tc_ns.sv
module ptp_tc_ns #(
  parameter int unsigned NS_W    = 40,
  parameter int unsigned STEP_NS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            carry_up_i,
  input  logic            carry_dn_i,
  input  logic            load_i,
  input  logic [NS_W-1:0] load_ns_i,
  output logic [NS_W-1:0] ns_o
);
  localparam logic [NS_W-1:0] STEP_V = NS_W'(STEP_NS);

  logic [NS_W-1:0] ns_q;
  logic [NS_W-1:0] ns_next;

  assign ns_next = ns_q + STEP_V + NS_W'(carry_up_i) - NS_W'(carry_dn_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ns_q <= '0;
    else if (load_i) ns_q <= load_ns_i;
    else if (adv_i)  ns_q <= ns_next;
  end

  assign ns_o = ns_q;
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_W    = 40,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned STEP_NS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [NS_W-1:0]   time_ns_o,
  output logic [FRAC_W-1:0] time_frac_o
);
  logic             inc_neg;
  logic [MAG_W-1:0] inc_mag;
  logic             halt;
  logic             load;
  logic [NS_W-1:0]  load_ns;
  logic             adv;
  logic             carry_up;
  logic             carry_dn;

  // a load takes the cycle; the tick in it is dropped
  assign adv = tick_i && !halt && !load;

  ptp_tc_regs #(.NS_W(NS_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .re_i      (reg_re_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .live_ns_i (time_ns_o),
    .rdata_o   (reg_rdata_o),
    .inc_neg_o (inc_neg),
    .inc_mag_o (inc_mag),
    .halt_o    (halt),
    .load_o    (load),
    .load_ns_o (load_ns)
  );

  ptp_tc_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .clr_i      (load),
    .neg_i      (inc_neg),
    .mag_i      (inc_mag),
    .frac_o     (time_frac_o),
    .carry_up_o (carry_up),
    .carry_dn_o (carry_dn)
  );

  ptp_tc_ns #(.NS_W(NS_W), .STEP_NS(STEP_NS)) u_ns (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .carry_up_i (carry_up),
    .carry_dn_i (carry_dn),
    .load_i     (load),
    .load_ns_i  (load_ns),
    .ns_o       (time_ns_o)
  );
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk
  import ptp_tc_pkg::*;
#(
  parameter int unsigned NS_W    = 40,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned STEP_NS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              halt_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [1:0]        reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic [NS_W-1:0]   time_ns_o,
  input logic [FRAC_W-1:0] time_frac_o
);
  localparam int unsigned    HI_W = NS_W - 32;
  localparam logic [NS_W-1:0] D_LO = NS_W'(STEP_NS - 1);
  localparam logic [NS_W-1:0] D_NM = NS_W'(STEP_NS);
  localparam logic [NS_W-1:0] D_HI = NS_W'(STEP_NS + 1);

  logic hi_wr;
  logic hi_rd;
  assign hi_wr = reg_we_i && slot_e'(reg_addr_i) == SLOT_TIME_HI;
  assign hi_rd = reg_re_i && slot_e'(reg_addr_i) == SLOT_TIME_HI;

  assert_halt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !hi_wr |=> $stable(time_ns_o) && $stable(time_frac_o));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !hi_wr |=> $stable(time_ns_o) && $stable(time_frac_o));

  // R4 and R5: one tick moves the count by step-1, step or step+1
  assert_step_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !halt_i && !hi_wr |=>
      ((time_ns_o - $past(time_ns_o)) == D_LO) ||
      ((time_ns_o - $past(time_ns_o)) == D_NM) ||
      ((time_ns_o - $past(time_ns_o)) == D_HI));

  assert_load_clears_frac_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> time_frac_o == '0);

  assert_hi_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd |-> (reg_rdata_o >> HI_W) == 32'd0);

  assert_no_read_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |-> reg_rdata_o == 32'd0);
endmodule

bind ptp_time_counter ptp_time_counter_chk #(
  .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_NS(STEP_NS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .halt_i      (halt),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .time_ns_o   (time_ns_o),
  .time_frac_o (time_frac_o)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_re_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [39:0] time_ns_o;
  logic [31:0] time_frac_o;

  int n_vec = 0;
  int n_bad = 0;

  // model: {ns, frac} as one 72-bit quantity
  logic [71:0] m_t = '0;
  logic [31:0] m_inc = '0;
  logic        m_halt = 1'b1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ptp_time_counter u_dut (
    .clk_i, .rst_ni, .tick_i, .reg_we_i, .reg_re_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .time_ns_o, .time_frac_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_time(input string tag);
    chk({tag, " ns"},   64'(time_ns_o),   64'(m_t[71:32]));
    chk({tag, " frac"}, 64'(time_frac_o), 64'(m_t[31:0]));
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  function automatic void model_tick();
    if (!m_halt) begin
      m_t = m_t + (72'd8 << 32);
      if (m_inc[31]) m_t = m_t - 72'(m_inc[30:0]);
      else           m_t = m_t + 72'(m_inc[30:0]);
    end
  endfunction

  task automatic run_ticks(input int n, input string tag);
    @(negedge clk_i);
    tick_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (k == n - 1) tick_i = 1'b0;
      model_tick();
      chk_time(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [30:0] mag;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk_time("R1");
    rd(2'd3, d); chk("R1 aux", 64'(d), 64'h8000_0000);
    rd(2'd2, d); chk("R1 incr", 64'(d), 64'h0);

    // R2 halted after reset
    run_ticks(5, "R2 halted");

    wr(2'd3, 32'h0); m_halt = 1'b0;
    rd(2'd3, d); chk("R10 aux", 64'(d), 64'h0);
    @(negedge clk_i); chk_time("R3 idle");
    run_ticks(10, "R3 nominal");

    // R4 / R5 sweep over magnitudes and signs
    for (int i = 0; i < 5; i++) begin
      case (i)
        0: mag = 31'd1;
        1: mag = 31'h4000_0000;
        2: mag = 31'h7FFF_FFFF;
        3: mag = 31'h1234_5678;
        default: mag = 31'h0AAA_AAAB;
      endcase
      for (int s = 0; s < 2; s++) begin
        m_inc = {s[0], mag};
        wr(2'd2, m_inc);
        rd(2'd2, d); chk("R10 incr", 64'(d), 64'(m_inc));
        run_ticks(24, s ? "R5 negative" : "R4 positive");
      end
    end
    m_inc = '0; wr(2'd2, 32'h0);

    // R7 staged write
    wr(2'd0, 32'hFFFF_FFF0);
    chk_time("R7 staged only");
    wr(2'd1, 32'hABCD_EF00);
    m_t = {40'h00_FFFF_FFF0, 32'h0};
    chk_time("R7 loaded");

    // R6 snapshot across 2^32 boundary
    rd(2'd0, d); chk("R6 lo", 64'(d), 64'hFFFF_FFF0);
    run_ticks(4, "R6 advance");
    rd(2'd1, d); chk("R6 hi snapshot", 64'(d), 64'h0);
    rd(2'd0, d); chk("R6 lo live", 64'(d), 64'h10);
    rd(2'd1, d); chk("R6 hi new", 64'(d), 64'h1);

    // R8 reserved high bits
    wr(2'd1, 32'hABCD_EF12);
    m_t = {40'h12_FFFF_FFF0, 32'h0};
    chk_time("R8 load");
    rd(2'd0, d);
    rd(2'd1, d); chk("R8 hi", 64'(d), 64'h12);

    // R9 wrap
    wr(2'd0, 32'hFFFF_FFF8);
    wr(2'd1, 32'h0000_00FF);
    m_t = {40'hFF_FFFF_FFF8, 32'h0};
    chk_time("R9 preload");
    run_ticks(1, "R9 wrap");
    chk("R9 zero", 64'(time_ns_o), 64'h0);

    // R11 write beats tick
    m_inc = 32'h0000_1000; wr(2'd2, m_inc);
    run_ticks(3, "R4 frac set");
    wr(2'd0, 32'h0000_0100);
    @(negedge clk_i);
    tick_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 32'h0;
    @(negedge clk_i);
    tick_i = 1'b0; reg_we_i = 1'b0;
    m_t = {40'h100, 32'h0};
    chk_time("R11");

    // R2 halt mid-run
    m_inc = 32'h4000_0000; wr(2'd2, m_inc);
    run_ticks(3, "R4 pre-halt");
    wr(2'd3, 32'h8000_0000); m_halt = 1'b1;
    rd(2'd3, d); chk("R10 aux halt", 64'(d), 64'h8000_0000);
    run_ticks(6, "R2 halted run");
    wr(2'd3, 32'h7FFF_FFFF); m_halt = 1'b0;
    run_ticks(4, "R2 resumed");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule